// File: doc/BRIEF.md
# Memory Write DMA Bus Controller

This block moves a write payload, already placed in a byte-wide staging buffer by a command handler, into user memory or registers over a simple shared bus. The handler fills the staging buffer from byte index 0 and then starts a transfer with a word address and a byte count. The controller requests the bus and waits for a grant. On the first grant it acknowledges the start to the handler. It then issues one bus write per word, each held until the bus target acknowledges it.

Payload bytes are packed into bus words in a fixed order selected by a parameter. A short final word enables only the lanes that carry payload. The number of words written per bus grant is capped. When the cap is reached the controller gives up the bus for a cycle and asks for it again. A watchdog limits how long the controller waits for a grant or for a write acknowledge. When it expires the transfer stops, the bus is released, and an error pulse is given instead of the done pulse.

Top module: `mem_write_dma`

## Requirements
- R1: After a synchronous reset, bus_req, bus_wr, start_ack, done and err are all low.
- R2: A start seen while idle raises bus_req on the next clock edge; bus_wr is never high while bus_req is low, and no write is issued before a grant.
- R3: start_ack is a one-cycle pulse, given exactly once per transfer, on the edge after the first sampled grant.
- R4: Payload byte i is written to bus word address start_addr + i/NB, where NB = DATA_W/8. With BIG_END=0 it lands in byte lane i mod NB, and lane k occupies bus_wdata bits [8k+7:8k]. Each write holds address and data stable until bus_ack.
- R5: Every lane of a full word is enabled. The last word of a transfer whose byte count is not a multiple of NB enables only the (count mod NB) lanes holding payload.
- R6: At most MAX_BURST writes are acknowledged during one continuous bus_req assertion. When more words remain, bus_req drops for at least one cycle and is then raised again.
- R7: After the acknowledge of the last word, bus_req drops and done pulses for one cycle on the same edge. err stays low.
- R8: If no grant arrives within WDOG_CYCLES consecutive requesting cycles, bus_req drops and err pulses for one cycle. done is not raised and no write is issued.
- R9: If a write is not acknowledged within WDOG_CYCLES cycles, bus_wr and bus_req drop and err pulses for one cycle without done.
- R10: A byte count of zero still obtains a grant and gives start_ack, then raises done with no bus write.
- R11: With BIG_END=1, payload byte i lands in lane NB-1-(i mod NB), and a short final word enables the matching upper lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transfer start request from the command handler, sampled while idle |
| start_addr | input | ADDR_W | Bus word address of the first payload word |
| byte_count | input | CNT_W | Payload length in bytes |
| start_ack | output | 1 | One-cycle pulse when the bus is first granted |
| done | output | 1 | One-cycle pulse when the transfer completes |
| err | output | 1 | One-cycle pulse when the watchdog aborts the transfer |
| stg_wr | input | 1 | Staging buffer byte write enable |
| stg_idx | input | IDX_W | Staging buffer byte index |
| stg_byte | input | 8 | Staging buffer byte data |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_be | output | NB | Bus byte-lane enables |
| bus_wr | output | 1 | Write strobe, held until acknowledged |
| bus_ack | input | 1 | Write acknowledge from the bus target |

## Verification
A wrong packing or staging read pointer shows up as a bad byte or address on the first write that follows it. The scoreboard compares every acknowledged write against the queue, so such a fault is seen within one bus cycle. A miscounted burst or byte counter shows up at a tenure boundary: too many writes under one request, a missing gap, or done arriving early or late. All of these are visible within one burst. A watchdog that counts wrongly moves the err pulse outside a window a few cycles wide around WDOG_CYCLES, and a stuck state leaves done and err silent until the transfer timeout.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_WR,
    ST_GAP
  } mwd_state_t;

endpackage

// File: rtl/mwd_stage_ram.sv
// Staging buffer split into one byte bank per lane position, so a whole bus
// word is read per cycle. Each bank has a synchronous read (block RAM style).
module mwd_stage_ram #(
  parameter int NB      = 4,
  parameter int IDX_W   = 10,
  parameter bit BIG_END = 1'b0
) (
  input  logic                            clk,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [7:0]                      wr_byte,
  input  logic [IDX_W-$clog2(NB)-1:0]     rd_word,
  output logic [NB*8-1:0]                 rd_data
);
  localparam int LANE_W = $clog2(NB);
  localparam int WORD_W = IDX_W - LANE_W;
  localparam int WORDS  = 1 << WORD_W;

  logic [LANE_W-1:0] wr_bank;
  logic [WORD_W-1:0] wr_word;

  assign wr_bank = wr_idx[LANE_W-1:0];
  assign wr_word = wr_idx[IDX_W-1:LANE_W];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int LANE = BIG_END ? (NB - 1 - b) : b;
    logic [7:0] mem [WORDS];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == LANE_W'(b))) begin
        mem[wr_word] <= wr_byte;
      end
      q <= mem[rd_word];
    end

    assign rd_data[LANE*8 +: 8] = q;
  end

endmodule

// File: rtl/mwd_watchdog.sv
// Counts consecutive waiting cycles and flags expiry on the last allowed one.
module mwd_watchdog #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = run && (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/mem_write_dma.sv
module mem_write_dma #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 16,
  parameter int BUF_BYTES   = 1024,
  parameter int MAX_BURST   = 8,
  parameter int WDOG_CYCLES = 256,
  parameter bit BIG_END     = 1'b0,
  localparam int NB         = DATA_W / 8,
  localparam int IDX_W      = $clog2(BUF_BYTES),
  localparam int CNT_W      = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  output logic              start_ack,
  output logic              done,
  output logic              err,
  input  logic              stg_wr,
  input  logic [IDX_W-1:0]  stg_idx,
  input  logic [7:0]        stg_byte,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [NB-1:0]     bus_be,
  output logic              bus_wr,
  input  logic              bus_ack
);
  import mwd_pkg::*;

  localparam int LANE_W  = $clog2(NB);
  localparam int WORD_W  = IDX_W - LANE_W;
  localparam int BURST_W = $clog2(MAX_BURST + 1);

  mwd_state_t        state;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] word_idx;
  logic [WORD_W-1:0] rd_word;
  logic [CNT_W-1:0]  bytes_left;
  logic [BURST_W-1:0] burst_cnt;
  logic              first_q;
  logic [DATA_W-1:0] rd_data;
  logic [NB-1:0]     be_next;
  logic              wd_run;
  logic              wd_exp;
  logic              last_word;
  logic              burst_full;

  // Read address runs one word ahead as soon as the current write is accepted,
  // so the banked RAM output is valid in the following read cycle.
  assign rd_word = (state == ST_WR && bus_ack) ? word_idx + 1'b1 : word_idx;

  mwd_stage_ram #(
    .NB      (NB),
    .IDX_W   (IDX_W),
    .BIG_END (BIG_END)
  ) u_stage (
    .clk     (clk),
    .wr_en   (stg_wr),
    .wr_idx  (stg_idx),
    .wr_byte (stg_byte),
    .rd_word (rd_word),
    .rd_data (rd_data)
  );

  assign wd_run = (state == ST_REQ && !bus_gnt) || (state == ST_WR && !bus_ack);

  mwd_watchdog #(
    .LIMIT (WDOG_CYCLES)
  ) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .run     (wd_run),
    .expired (wd_exp)
  );

  // Lane enables for the word about to be written, in bus lane order.
  always_comb begin
    be_next = '0;
    for (int j = 0; j < NB; j++) begin
      if (bytes_left > CNT_W'(j)) begin
        be_next[BIG_END ? (NB - 1 - j) : j] = 1'b1;
      end
    end
  end

  assign last_word  = (bytes_left <= CNT_W'(NB));
  assign burst_full = (burst_cnt == BURST_W'(MAX_BURST - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      word_idx   <= '0;
      bytes_left <= '0;
      burst_cnt  <= '0;
      first_q    <= 1'b0;
      start_ack  <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      bus_req    <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      bus_be     <= '0;
      bus_wr     <= 1'b0;
    end else begin
      start_ack <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            addr_q     <= start_addr;
            bytes_left <= byte_count;
            word_idx   <= '0;
            first_q    <= 1'b1;
            bus_req    <= 1'b1;
            state      <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_gnt) begin
            first_q   <= 1'b0;
            start_ack <= first_q;
            burst_cnt <= '0;
            if (bytes_left == '0) begin
              bus_req <= 1'b0;
              done    <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              state <= ST_RD;
            end
          end else if (wd_exp) begin
            bus_req <= 1'b0;
            err     <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_RD: begin
          bus_addr  <= addr_q;
          bus_wdata <= rd_data;
          bus_be    <= be_next;
          bus_wr    <= 1'b1;
          state     <= ST_WR;
        end
        ST_WR: begin
          if (bus_ack) begin
            bus_wr    <= 1'b0;
            addr_q    <= addr_q + 1'b1;
            word_idx  <= word_idx + 1'b1;
            burst_cnt <= burst_cnt + 1'b1;
            if (last_word) begin
              bytes_left <= '0;
              bus_req    <= 1'b0;
              done       <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              bytes_left <= bytes_left - CNT_W'(NB);
              if (burst_full) begin
                bus_req <= 1'b0;
                state   <= ST_GAP;
              end else begin
                state <= ST_RD;
              end
            end
          end else if (wd_exp) begin
            bus_wr  <= 1'b0;
            bus_req <= 1'b0;
            err     <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_GAP: begin
          bus_req <= 1'b1;
          state   <= ST_REQ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mwd_checker.sv
module mwd_checker #(
  parameter int NB        = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_wr,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NB-1:0]     bus_be,
  input logic              start_ack,
  input logic              done,
  input logic              err
);
  localparam int BW = $clog2(MAX_BURST + 2);

  logic [BW-1:0] tenure_acks;

  always_ff @(posedge clk) begin
    if (rst || !bus_req) begin
      tenure_acks <= '0;
    end else if (bus_wr && bus_ack) begin
      tenure_acks <= tenure_acks + 1'b1;
    end
  end

  p_wr_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> bus_req);

  p_ack_single_r3: assert property (@(posedge clk) disable iff (rst)
    start_ack |=> !start_ack);

  p_ack_after_gnt_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(start_ack) |-> $past(bus_gnt));

  p_wr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_ack && !err) |=> (bus_wr || err) && $stable(bus_addr) && $stable(bus_wdata));

  p_be_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> (bus_be != '0));

  p_burst_bound_r6: assert property (@(posedge clk) disable iff (rst)
    tenure_acks <= BW'(MAX_BURST));

  p_done_release_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_req && !bus_wr && !err));

  p_err_release_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> (!bus_req && !bus_wr && !done));

endmodule

bind mem_write_dma mwd_checker #(
  .NB        (NB),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .MAX_BURST (MAX_BURST)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_wr    (bus_wr),
  .bus_ack   (bus_ack),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_be    (bus_be),
  .start_ack (start_ack),
  .done      (done),
  .err       (err)
);

// File: tb/tb_mem_write_dma.sv
module tb_mem_write_dma;
  localparam int DW  = 32;
  localparam int AW  = 16;
  localparam int BUF = 64;
  localparam int MB  = 4;
  localparam int WD  = 16;
  localparam int NB  = DW / 8;
  localparam int IW  = $clog2(BUF);
  localparam int CW  = IW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          start = 0, start_be = 0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic          stg_wr = 0;
  logic [IW-1:0] stg_idx = '0;
  logic [7:0]    stg_byte = '0;
  logic          bus_gnt = 0, bus_ack = 0;
  logic          start_ack, done, err, bus_req, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [NB-1:0] bus_be;

  logic          ack_b, done_b, err_b, req_b, wr_b;
  logic [AW-1:0] addr_b;
  logic [DW-1:0] wdata_b;
  logic [NB-1:0] be_b;

  mem_write_dma #(.DATA_W(DW), .ADDR_W(AW), .BUF_BYTES(BUF), .MAX_BURST(MB),
                  .WDOG_CYCLES(WD), .BIG_END(1'b0)) dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .start_ack(start_ack), .done(done), .err(err),
    .stg_wr(stg_wr), .stg_idx(stg_idx), .stg_byte(stg_byte),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_wr(bus_wr), .bus_ack(bus_ack));

  // Big-endian variant: grant follows request, every write acknowledged at once.
  mem_write_dma #(.DATA_W(DW), .ADDR_W(AW), .BUF_BYTES(BUF), .MAX_BURST(MB),
                  .WDOG_CYCLES(WD), .BIG_END(1'b1)) dut_be (
    .clk(clk), .rst(rst), .start(start_be), .start_addr(start_addr),
    .byte_count(byte_count), .start_ack(ack_b), .done(done_b), .err(err_b),
    .stg_wr(stg_wr), .stg_idx(stg_idx), .stg_byte(stg_byte),
    .bus_req(req_b), .bus_gnt(req_b), .bus_addr(addr_b),
    .bus_wdata(wdata_b), .bus_be(be_b), .bus_wr(wr_b), .bus_ack(1'b1));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [NB-1:0] be;
  } wr_item_t;

  wr_item_t exp_q[$];

  // Bus slave model settings
  int  gnt_delay = 0, ack_delay = 0;
  bit  gnt_block = 0, ack_block = 0;
  int  n_writes = 0, n_start_ack = 0, n_gaps = 0, tenure = 0, max_tenure = 0;
  bit  busy = 0;

  // Bus slave and scoreboard monitor, acting on falling edges.
  initial begin
    int req_cyc = 0, wr_cyc = 0;
    bit req_prev = 0;
    forever begin
      @(negedge clk);
      if (bus_req) req_cyc++; else req_cyc = 0;
      bus_gnt = bus_req && !gnt_block && (req_cyc > gnt_delay);
      if (bus_wr && !bus_ack && !ack_block) begin
        wr_cyc++;
        bus_ack = (wr_cyc > ack_delay);
      end else begin
        bus_ack = 1'b0;
        wr_cyc  = 0;
      end
      if (start_ack) n_start_ack++;
      if (req_prev && !bus_req && busy && !done && !err) n_gaps++;
      req_prev = bus_req;
      if (!bus_req) tenure = 0;
      if (bus_ack) begin
        wr_item_t e;
        logic [DW-1:0] m;
        n_writes++;
        tenure++;
        if (tenure > max_tenure) max_tenure = tenure;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", $sformatf("unexpected write addr=%h data=%h be=%b, expected none",
              bus_addr, bus_wdata, bus_be));
        end else begin
          e = exp_q.pop_front();
          m = '0;
          for (int k = 0; k < NB; k++) if (e.be[k]) m[k*8 +: 8] = 8'hFF;
          chk(bus_addr == e.addr && (bus_wdata & m) == e.data,
              "R4", $sformatf("addr/data %h/%h expected %h/%h", bus_addr, bus_wdata & m, e.addr, e.data));
          chk(bus_be == e.be, "R5", $sformatf("be %b expected %b", bus_be, e.be));
        end
      end
    end
  end

  // Driver: pushes expected writes, starts a transfer and waits for its end.
  task automatic run_xfer(input int addr, input int cnt, input bit expect_wr,
                          output bit got_done, output bit got_err, output int cyc);
    int nw = (cnt + NB - 1) / NB;
    got_done = 0; got_err = 0; cyc = 0;
    if (expect_wr) begin
      for (int w = 0; w < nw; w++) begin
        wr_item_t e;
        e.addr = AW'(addr + w);
        e.data = '0;
        e.be   = '0;
        for (int j = 0; j < NB; j++) begin
          if (w * NB + j < cnt) begin
            e.data[j*8 +: 8] = pat(w * NB + j);
            e.be[j] = 1'b1;
          end
        end
        exp_q.push_back(e);
      end
    end
    n_start_ack = 0; n_gaps = 0; max_tenure = 0;
    busy = 1;
    start_addr = AW'(addr);
    byte_count = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: request raised one edge after start, no write yet
    chk(bus_req && !bus_wr, "R2", $sformatf("req=%b wr=%b expected req=1 wr=0", bus_req, bus_wr));
    while (!got_done && !got_err && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (done) got_done = 1;
      if (err) got_err = 1;
    end
    busy = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit d, e;
    int c, w0;
    logic [DW-1:0] bw [2];
    logic [NB-1:0] bb [2];
    int nb;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bus_req && !bus_wr && !start_ack && !done && !err, "R1",
        $sformatf("req=%b wr=%b ack=%b done=%b err=%b expected all 0",
                  bus_req, bus_wr, start_ack, done, err));
    rst = 1'b0;
    for (int i = 0; i < BUF; i++) begin
      stg_wr = 1'b1; stg_idx = IW'(i); stg_byte = pat(i);
      @(negedge clk);
    end
    stg_wr = 1'b0;
    @(negedge clk);

    // R4 R5 R7: short transfer with a partial final word
    gnt_delay = 2; ack_delay = 1;
    w0 = n_writes;
    run_xfer(16'h0100, 10, 1, d, e, c);
    chk(d && !e, "R7", $sformatf("done=%b err=%b expected 1/0", d, e));
    chk(n_writes - w0 == 3 && exp_q.size() == 0, "R4",
        $sformatf("writes=%0d expected 3", n_writes - w0));
    chk(n_start_ack == 1, "R3", $sformatf("start_ack pulses=%0d expected 1", n_start_ack));

    // R6: long transfer split into bursts
    gnt_delay = 0; ack_delay = 0;
    w0 = n_writes;
    run_xfer(16'h0200, 40, 1, d, e, c);
    chk(d && exp_q.size() == 0 && n_writes - w0 == 10, "R6",
        $sformatf("done=%b writes=%0d expected 1/10", d, n_writes - w0));
    chk(max_tenure <= MB, "R6", $sformatf("max writes per grant=%0d expected <=%0d", max_tenure, MB));
    chk(n_gaps >= 2, "R6", $sformatf("request gaps=%0d expected >=2", n_gaps));
    chk(n_start_ack == 1, "R3", $sformatf("start_ack pulses=%0d expected 1", n_start_ack));

    // R5: three-byte tail, then exact multiple
    gnt_delay = 1; ack_delay = 3;
    run_xfer(16'h0300, 7, 1, d, e, c);
    chk(d && exp_q.size() == 0, "R5", $sformatf("done=%b pending=%0d expected 1/0", d, exp_q.size()));
    run_xfer(16'h0010, 4, 1, d, e, c);
    chk(d && exp_q.size() == 0, "R4", $sformatf("done=%b pending=%0d expected 1/0", d, exp_q.size()));

    // R10: zero byte count
    w0 = n_writes;
    run_xfer(16'h0400, 0, 0, d, e, c);
    chk(d && !e && n_writes == w0 && n_start_ack == 1, "R10",
        $sformatf("done=%b writes=%0d acks=%0d expected 1/0/1", d, n_writes - w0, n_start_ack));

    // R8: grant never arrives
    gnt_block = 1; w0 = n_writes;
    run_xfer(16'h0500, 8, 0, d, e, c);
    chk(e && !d && n_writes == w0, "R8", $sformatf("err=%b done=%b expected 1/0", e, d));
    chk(c >= WD - 1 && c <= WD + 3, "R8", $sformatf("err after %0d cycles expected about %0d", c, WD));
    chk(!bus_req && !bus_wr, "R8", $sformatf("req=%b wr=%b expected 0/0", bus_req, bus_wr));
    gnt_block = 0;

    // R9: write acknowledge never arrives
    ack_block = 1; gnt_delay = 0; w0 = n_writes;
    run_xfer(16'h0600, 8, 0, d, e, c);
    chk(e && !d && n_writes == w0, "R9", $sformatf("err=%b done=%b expected 1/0", e, d));
    chk(!bus_req && !bus_wr, "R9", $sformatf("req=%b wr=%b expected 0/0", bus_req, bus_wr));
    ack_block = 0;

    // R11: big-endian variant, 6 bytes
    start_addr = 16'h0040; byte_count = CW'(6);
    start_be = 1'b1;
    @(negedge clk);
    start_be = 1'b0;
    nb = 0;
    for (int i = 0; i < 40 && !done_b; i++) begin
      @(negedge clk);
      if (wr_b && nb < 2) begin
        bw[nb] = wdata_b; bb[nb] = be_b; nb++;
      end
    end
    chk(nb == 2, "R11", $sformatf("writes=%0d expected 2", nb));
    if (nb == 2) begin
      chk(bw[0] == {pat(0), pat(1), pat(2), pat(3)} && bb[0] == 4'b1111, "R11",
          $sformatf("word0 %h/%b expected %h/1111", bw[0], bb[0], {pat(0), pat(1), pat(2), pat(3)}));
      chk(bw[1][31:16] == {pat(4), pat(5)} && bb[1] == 4'b1100, "R11",
          $sformatf("word1 %h/%b expected %h/1100", bw[1][31:16], bb[1], {pat(4), pat(5)}));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule